// File: doc/BRIEF.md
# Serial Port with Receive and Transmit Queues

This block is an asynchronous serial port attached to a small register bus. Software writes characters into a transmit queue and the transmitter sends each one as a frame: a low start bit, 5 to 8 data bits least significant first, an optional parity bit and one or two high stop bits. The receiver oversamples the incoming line at 16 times the bit rate. It checks each frame it sees and stores the character in a receive queue together with its own error flags. Software later reads the character and its flags back as one word.

The bus has two locations. Address 0 is the data location: a write queues a character and a read takes the oldest received word. Address 1 is a 19-bit control word that sets the divisor, break, parity, stop bits, queue enable and word length. Flags for receive-empty, transmit-full and transmitter-busy are brought out as pins. There is one interrupt line for each direction, and an enable input switches the whole port on or off.

Top module: `uart_fifo_port`

## Requirements
- R1: A read at address 0 returns the oldest received entry: character in bits 7:0, framing error in bit 8, parity error in bit 9, overrun in bit 10, upper bits zero. The read removes that entry. A read with the receive queue empty returns 0.
- R2: Control bits 11:0 hold a value D. Every transmitted bit lasts exactly 16*(D+1) clock cycles, and the receiver uses the same bit period.
- R3: While control bit 12 is set, tx_o is held low whatever else the transmitter is doing. Once it clears, the line follows the transmitter again.
- R4: Control bit 13 adds a parity bit after the data bits. Control bit 14 set selects even parity and clear selects odd parity. A received frame whose parity does not match sets bit 9 of its entry.
- R5: A frame is a low start bit, the data bits least significant first, the parity bit if enabled, then one high stop bit, or two when control bit 15 is set. tx_busy falls exactly one full frame length after the start bit began, when nothing else is queued.
- R6: Control bits 18:17 give the word length, with codes 0, 1, 2 and 3 for 5, 6, 7 and 8 data bits. Received characters shorter than 8 bits have their unused upper bits zero.
- R7: With control bit 16 set, each queue holds 16 characters. With it clear, each holds one. A data write to a full transmit queue is dropped.
- R8: rx_empty is high when no received entry is stored. tx_full is high when the transmit queue is at capacity. tx_busy is high while characters are queued or a frame is still being shifted out.
- R9: When a frame completes while the receive queue is full, the frame is discarded. The next entry that is stored then carries the overrun flag in bit 10.
- R10: A receive frame whose first stop bit samples low sets bit 8 of its entry. The receiver does not accept a new start bit until the line has returned high.
- R11: irq_rx is high when the port is enabled and a received entry is waiting. irq_tx is high when the port is enabled and the transmit queue is empty.
- R12: With port_en low, both queues are emptied, the transmitter and receiver are idle, tx_o is high (unless break is set), data writes are ignored and both interrupts are low.
- R13: The control word reads back at address 1 as written, and it can be written while the port is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data location, 1 = control word |
| bus_wdata | input | 19 | Write data |
| bus_rdata | output | 19 | Read data (combinational) |
| rx_i | input | 1 | Serial input |
| tx_o | output | 1 | Serial output |
| rx_empty | output | 1 | Receive queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_busy | output | 1 | Transmitter has queued or in-flight data |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default parameters: a queue depth of 16 and a 12-bit divisor field. Most traffic runs at divisors 0 to 2, so each frame takes only a few hundred cycles and random word lengths, parity and stop settings can be covered in bulk. The largest divisor, 4095, is used to hold the transmitter still while the queue is filled past its capacity in both the 16-entry and the single-entry modes. The overrun tests deliberately overfill the receive queue in both modes.

// File: rtl/uart_fifo_port.sv
module uart_fifo_port #(
  parameter int DEPTH = 16,
  parameter int DIVW = 12,
  localparam int CW = DIVW + 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          rx_i,
  output logic          tx_o,
  output logic          rx_empty,
  output logic          tx_full,
  output logic          tx_busy,
  output logic          irq_tx,
  output logic          irq_rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [CW-1:0] ctrl;
  wire [DIVW-1:0] div = ctrl[DIVW-1:0];
  wire brk = ctrl[DIVW];
  wire par_en = ctrl[DIVW+1];
  wire par_even = ctrl[DIVW+2];
  wire stop2 = ctrl[DIVW+3];
  wire fifo_en = ctrl[DIVW+4];
  wire [3:0] nd = 4'd5 + {2'b00, ctrl[DIVW+6:DIVW+5]};
  wire [NW-1:0] cap = fifo_en ? NW'(DEPTH) : NW'(1);

  wire wr_data = bus_sel & bus_wr & ~bus_addr & port_en;
  wire wr_ctrl = bus_sel & bus_wr & bus_addr;
  wire rd_data = bus_sel & ~bus_wr & ~bus_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else if (wr_ctrl) ctrl <= bus_wdata;

  logic [DIVW-1:0] divcnt;
  wire tick = port_en && (divcnt >= div);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) divcnt <= '0;
    else if (!port_en || tick) divcnt <= '0;
    else divcnt <= divcnt + 1'b1;

  // transmit queue
  logic [7:0] txm [DEPTH];
  logic [AW-1:0] txw, txr;
  logic [NW-1:0] txc;
  logic tx_act;
  assign tx_full = txc >= cap;
  wire tx_push = wr_data & ~tx_full;
  wire tx_load = tick & ~tx_act & (txc != '0);

  always_ff @(posedge clk)
    if (tx_push) txm[txw] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txw <= '0; txr <= '0; txc <= '0;
    end else if (!port_en) begin
      txw <= '0; txr <= '0; txc <= '0;
    end else begin
      if (tx_push) txw <= nxt(txw);
      if (tx_load) txr <= nxt(txr);
      txc <= txc + NW'(tx_push) - NW'(tx_load);
    end

  // transmit shifter
  logic [11:0] tframe, tsr;
  logic [3:0] tlen, tbits, tcnt;
  logic tpar;
  always_comb begin
    tframe = '1;
    tframe[0] = 1'b0;
    tpar = ~par_even;
    for (int i = 0; i < 8; i++)
      if (i < int'(nd)) begin
        tframe[i+1] = txm[txr][i];
        tpar = tpar ^ txm[txr][i];
      end
    if (par_en) tframe[4'd1 + nd] = tpar;
    tlen = 4'd2 + nd + {3'b000, par_en} + {3'b000, stop2};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_act <= 1'b0; tsr <= '1; tbits <= '0; tcnt <= '0;
    end else if (!port_en) begin
      tx_act <= 1'b0; tsr <= '1;
    end else if (tx_load) begin
      tx_act <= 1'b1; tsr <= tframe; tbits <= tlen; tcnt <= '0;
    end else if (tx_act && tick) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == 4'd15) begin
        tsr <= {1'b1, tsr[11:1]};
        tbits <= tbits - 1'b1;
        if (tbits == 4'd1) tx_act <= 1'b0;
      end
    end

  assign tx_o = ~brk & tsr[0];
  assign tx_busy = tx_act | (txc != '0);
  assign irq_tx = port_en & (txc == '0);

  // receiver
  logic [1:0] rsy;
  wire rxs = rsy[1];
  logic rx_run, rx_arm, racc, ovr_pend;
  logic [3:0] scnt, rbi;
  logic [7:0] rdat;
  wire [3:0] rstop = 4'd1 + nd + {3'b000, par_en};
  wire mid = rx_run & tick & (scnt == 4'd7);
  wire frame_end = mid & (rbi == rstop);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsy <= '1;
    else rsy <= {rsy[0], rx_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_run <= 1'b0; rx_arm <= 1'b0; racc <= 1'b0;
      scnt <= '0; rbi <= '0; rdat <= '0;
    end else if (!port_en) begin
      rx_run <= 1'b0; rx_arm <= 1'b0;
    end else if (!rx_run) begin
      if (rxs) rx_arm <= 1'b1;
      if (tick && rx_arm && !rxs) begin
        rx_run <= 1'b1; scnt <= 4'd1; rbi <= '0; racc <= 1'b0;
      end
    end else if (tick) begin
      scnt <= scnt + 1'b1;
      if (scnt == 4'd7) begin
        rbi <= rbi + 1'b1;
        if (rbi == 4'd0) begin
          if (rxs) rx_run <= 1'b0;
        end else if (rbi <= nd) begin
          rdat <= {rxs, rdat[7:1]};
          racc <= racc ^ rxs;
        end else if (rbi < rstop) begin
          racc <= racc ^ rxs;
        end
        if (rbi == rstop) begin
          rx_run <= 1'b0; rx_arm <= 1'b0;
        end
      end
    end

  wire [7:0] rx_char = 8'(rdat >> (4'd8 - nd));
  wire rx_perr = par_en & (racc == par_even);
  wire [10:0] rx_ent = {ovr_pend, rx_perr, ~rxs, rx_char};

  // receive queue
  logic [10:0] rxm [DEPTH];
  logic [AW-1:0] rxw, rxr;
  logic [NW-1:0] rxc;
  assign rx_empty = (rxc == '0);
  wire rx_push = frame_end & (rxc < cap);
  wire rx_pop = rd_data & ~rx_empty;

  always_ff @(posedge clk)
    if (rx_push) rxm[rxw] <= rx_ent;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxw <= '0; rxr <= '0; rxc <= '0; ovr_pend <= 1'b0;
    end else if (!port_en) begin
      rxw <= '0; rxr <= '0; rxc <= '0; ovr_pend <= 1'b0;
    end else begin
      if (rx_push) rxw <= nxt(rxw);
      if (rx_pop) rxr <= nxt(rxr);
      rxc <= rxc + NW'(rx_push) - NW'(rx_pop);
      if (rx_push) ovr_pend <= 1'b0;
      else if (frame_end) ovr_pend <= 1'b1;
    end

  assign irq_rx = port_en & ~rx_empty;
  assign bus_rdata = bus_addr ? ctrl : (rx_empty ? '0 : CW'(rxm[rxr]));

  assert_tx_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txc > $past(txc)) |-> ($past(txc) < $past(cap)));

  assert_rx_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxc > $past(rxc)) |-> ($past(rxc) < $past(cap)));

  assert_overrun_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_pend) |-> ($past(rxc) >= $past(cap)));

  assert_flush_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (txc == '0 && rxc == '0 && !tx_act));

  assert_busy_ends_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_busy) && $past(port_en) && !$past(brk)) |-> $past(tx_o));

  assert_read_pops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rd_data && !rx_empty && !rx_push) |=> (rxc == $past(rxc) - 1'b1));
endmodule

// File: tb/sim_uart_fifo_port.sv
module sim_uart_fifo_port;
  logic clk = 1'b0, rst_n = 1'b0, port_en = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [18:0] bus_wdata = '0;
  logic [18:0] bus_rdata;
  logic rxl = 1'b1;
  logic tx_o, rx_empty, tx_full, tx_busy, irq_tx, irq_rx;
  int nchk = 0, nfail = 0;
  int unsigned cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_fifo_port u0 (.clk, .rst_n, .port_en, .bus_sel, .bus_wr, .bus_addr,
    .bus_wdata, .bus_rdata, .rx_i(rxl), .tx_o, .rx_empty, .tx_full,
    .tx_busy, .irq_tx, .irq_rx);

  function automatic logic [18:0] mk(int dv, int br, int pe, int ev, int s2, int fe, int wl);
    return {2'(wl - 5), 1'(fe), 1'(s2), 1'(ev), 1'(pe), 1'(br), 12'(dv)};
  endfunction

  function automatic logic [10:0] exp_ent(logic [7:0] d, int wl, bit fe, bit pe, bit ov);
    return {ov, pe, fe, d & 8'((1 << wl) - 1)};
  endfunction

  function automatic bit par_of(logic [7:0] d, int wl, int ev);
    return (^(d & 8'((1 << wl) - 1))) ^ !ev;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [18:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [18:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic send(input logic [7:0] d, int wl, int pe, int ev, int s2, bit bad_par, bit bad_stop, int P);
    logic [12:0] b; int n;
    b = '1; b[0] = 0;
    for (int i = 0; i < wl; i++) b[i+1] = d[i];
    n = 1 + wl;
    if (pe != 0) begin b[n] = par_of(d, wl, ev) ^ bad_par; n++; end
    b[n] = !bad_stop; n = n + 1 + s2;
    for (int i = 0; i < n; i++) begin
      rxl = b[i];
      repeat (P) @(negedge clk);
    end
    rxl = 1;
    repeat (P) @(negedge clk);
  endtask

  task automatic cap_tx(input int wl, int pe, int ev, int s2, int P, input logic [7:0] d, input bit cb, input string req);
    int unsigned c0;
    @(negedge clk);
    while (tx_o !== 1'b0) @(negedge clk);
    c0 = cyc;
    repeat (P / 2) @(negedge clk);
    chk({req, " start"}, tx_o, 0);
    for (int i = 0; i < wl; i++) begin
      repeat (P) @(negedge clk);
      chk({req, " data"}, tx_o, d[i]);
    end
    if (pe != 0) begin
      repeat (P) @(negedge clk);
      chk({req, " R4 parity"}, tx_o, par_of(d, wl, ev));
    end
    repeat (P) @(negedge clk);
    chk({req, " stop"}, tx_o, 1);
    if (cb) begin
      while (tx_busy) @(negedge clk);
      chk({req, " R5 R8 frame length"}, cyc - c0, (2 + wl + pe + s2) * P);
    end
  endtask

  task automatic no_tx(input int n, input string req);
    int lows = 0;
    repeat (n) begin @(negedge clk); if (tx_o !== 1'b1) lows++; end
    chk(req, lows, 0);
  endtask

  task automatic restart_div;
    @(negedge clk); port_en = 0;
    @(negedge clk); @(negedge clk); port_en = 1;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [18:0] r, c;
    int wl, pe, ev, s2, dv, P;
    logic [7:0] d;
    bit bp, bs;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset tx idle", tx_o, 1);
    chk("R8 reset rx_empty", rx_empty, 1);
    chk("R8 reset tx_full", tx_full, 0);
    chk("R8 reset tx_busy", tx_busy, 0);
    chk("R11 R12 irq off", {irq_tx, irq_rx}, 0);
    rd(1, r); chk("R13 reset ctrl", r, 0);

    // port disabled: writes ignored
    wr(1, mk(0, 0, 0, 0, 0, 1, 8));
    wr(0, 19'h55);
    repeat (40) @(negedge clk);
    chk("R12 write ignored busy", tx_busy, 0);
    chk("R12 line idle", tx_o, 1);
    port_en = 1;
    @(negedge clk);
    chk("R11 irq_tx empty", irq_tx, 1);
    chk("R12 nothing queued", tx_busy, 0);
    no_tx(60, "R12 no frame after enable");

    // control readback
    c = 19'($urandom) & ~19'(1 << 12);
    wr(1, c); rd(1, r); chk("R13 readback", r, c);
    wr(1, mk(0, 1, 0, 0, 0, 1, 8));
    chk("R3 break low", tx_o, 0);
    wr(1, mk(0, 0, 0, 0, 0, 1, 8));
    chk("R3 break released", tx_o, 1);

    // bit period
    wr(1, mk(2, 0, 0, 0, 0, 1, 8));
    wr(0, 19'hFF);
    begin
      int n = 0;
      while (tx_o !== 1'b0) @(negedge clk);
      while (tx_o === 1'b0) begin n++; @(negedge clk); end
      chk("R2 start bit width", n, 48);
    end
    while (tx_busy) @(negedge clk);

    // random transmit frames
    for (int k = 0; k < 14; k++) begin
      wl = 5 + $urandom_range(0, 3); pe = $urandom_range(0, 1); ev = $urandom_range(0, 1);
      s2 = $urandom_range(0, 1); dv = $urandom_range(0, 2); d = 8'($urandom);
      P = 16 * (dv + 1);
      wr(1, mk(dv, 0, pe, ev, s2, 1, wl));
      wr(0, {11'b0, d});
      cap_tx(wl, pe, ev, s2, P, d, 1, "R2 R5 R6 tx");
    end

    // fill the 16-entry transmit queue while stalled
    wr(1, mk(4095, 0, 0, 0, 0, 1, 8));
    restart_div();
    for (int i = 0; i < 17; i++) wr(0, 19'(8'h10 + i));
    chk("R7 tx_full at 16", tx_full, 1);
    chk("R8 busy queued", tx_busy, 1);
    chk("R11 irq_tx low", irq_tx, 0);
    wr(1, mk(0, 0, 0, 0, 0, 1, 8));
    for (int i = 0; i < 16; i++) cap_tx(8, 0, 0, 0, 16, 8'(8'h10 + i), i == 15, "R7 drain");
    no_tx(200, "R7 17th dropped");
    chk("R11 irq_tx back", irq_tx, 1);

    // single-entry transmit store
    wr(1, mk(4095, 0, 0, 0, 0, 0, 8));
    restart_div();
    wr(0, 19'hA5);
    chk("R7 one entry full", tx_full, 1);
    wr(0, 19'h5A);
    wr(1, mk(0, 0, 0, 0, 0, 0, 8));
    cap_tx(8, 0, 0, 0, 16, 8'hA5, 1, "R7 single");
    no_tx(200, "R7 single second dropped");

    // random receive frames
    for (int k = 0; k < 22; k++) begin
      wl = 5 + $urandom_range(0, 3); pe = $urandom_range(0, 1); ev = $urandom_range(0, 1);
      s2 = $urandom_range(0, 1); d = 8'($urandom);
      bp = (pe != 0) && ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 4) == 0);
      if (k == 0) begin wl = 8; pe = 1; ev = 1; bp = 1; bs = 0; end
      if (k == 1) begin wl = 5; pe = 0; bs = 1; bp = 0; end
      wr(1, mk(1, 0, pe, ev, s2, 1, wl));
      send(d, wl, pe, ev, s2, bp, bs, 32);
      chk("R8 rx not empty", rx_empty, 0);
      chk("R11 irq_rx", irq_rx, 1);
      rd(0, r);
      chk("R1 R4 R6 R10 rx entry", r, exp_ent(d, wl, bs, bp, 0));
      chk("R8 rx empty after read", rx_empty, 1);
    end
    rd(0, r); chk("R1 empty read", r, 0);

    // overrun with single-entry store
    wr(1, mk(1, 0, 0, 0, 0, 0, 8));
    send(8'h11, 8, 0, 0, 0, 0, 0, 32);
    send(8'h22, 8, 0, 0, 0, 0, 0, 32);
    send(8'h33, 8, 0, 0, 0, 0, 0, 32);
    rd(0, r); chk("R9 first kept", r, 19'h011);
    chk("R9 later dropped", rx_empty, 1);
    send(8'h44, 8, 0, 0, 0, 0, 0, 32);
    rd(0, r); chk("R9 overrun flag", r, 19'h444);

    // overrun with 16-entry queue
    wr(1, mk(1, 0, 0, 0, 0, 1, 8));
    for (int i = 0; i < 17; i++) send(8'(8'h60 + i), 8, 0, 0, 0, 0, 0, 32);
    for (int i = 0; i < 16; i++) begin
      rd(0, r); chk("R7 rx queue order", r, 19'(8'h60 + i));
    end
    chk("R7 17th not stored", rx_empty, 1);
    send(8'h7E, 8, 0, 0, 0, 0, 0, 32);
    rd(0, r); chk("R9 overrun after full queue", r, 19'h47E);

    // disable flushes
    send(8'h3C, 8, 0, 0, 0, 0, 0, 32);
    chk("R8 stored", rx_empty, 0);
    @(negedge clk); port_en = 0;
    @(negedge clk); @(negedge clk);
    chk("R12 rx flushed", rx_empty, 1);
    chk("R12 irq low", {irq_tx, irq_rx}, 0);
    port_en = 1;

    done = 1;
    report();
  end
endmodule